// File: doc/BRIEF.md
# Byte RAM with Per-Byte Hidden-Bit Sideband

This block is a byte-addressed memory that keeps, next to every data byte, one extra hidden bit in a separate sideband store. Hidden bits are held as two-bit pairs, one pair per 16-bit halfword. Byte and halfword writes update the hidden bits according to their size and address. Word, doubleword and burst writes change only the data. A client that later consumes the hidden bits, for example a pixel engine that keeps coverage information alongside colour, reads them back through a test-mode read. In that mode the usual data path is replaced by a four-bit packed view of two adjacent pairs.

Accesses are issued one per cycle on a single request port. The request carries a kind code, an address and either a right-justified scalar payload or a line-wide burst payload. Reads return one cycle later. A synchronous cold power-up input clears both stores. A synchronous soft reset only quiets the read output and leaves the memory contents untouched.

Top module: `mem_sideband`

## Requirements
- R1: The kind codes are 0 byte, 1 halfword, 2 word, 3 doubleword, 4 four-word burst and 5 eight-word burst. A read of kind 0 to 3 aligns the address down to its size and takes the address modulo MEM_BYTES. It raises rd_valid on the following cycle with the bytes in big-endian order, right-justified and zero-extended in rd_data. rd_data is zero whenever rd_valid is low.
- R2: A byte write stores req_wdata[7:0]. At an odd address it sets that byte's hidden bit to req_wdata[0]. At an even address it clears that byte's hidden bit.
- R3: A halfword write stores req_wdata[15:8] at the even byte and req_wdata[7:0] at the odd byte, and sets both hidden bits of the halfword to req_wdata[0].
- R4: Word and doubleword writes store their bytes big-endian from the low end of req_wdata and leave every hidden bit unchanged.
- R5: A four-word burst aligns its base down to 16 bytes and an eight-word burst aligns it down to 32 bytes. Word i comes from burst_wdata[32*i+31:32*i] and is stored big-endian at base+4*i. Hidden bits are left unchanged.
- R6: A burst write whose unaligned base address is at or above MEM_BYTES changes nothing.
- R7: With test_mode high at a read, rd_data[3:2] is the pair at halfword index h = aligned address / 2 and rd_data[1:0] is the pair at (h+1) modulo the pair count. Each pair is {hidden bit of even byte, hidden bit of odd byte}, and rd_data[63:4] is zero.
- R8: Reads of either kind alter neither data nor hidden bits.
- R9: With por_n low at a clock edge, all data bytes and hidden bits become zero and rd_valid is low after the edge.
- R10: With rst_n low and por_n high, requests are ignored, rd_valid is low after the edge, and all stored contents are kept.
- R11: Write requests, burst-kind reads and kinds 6 and 7 never raise rd_valid. Kinds 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-up clear, active low, synchronous |
| rst_n | input | 1 | Soft reset, active low, synchronous, keeps contents |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_kind | input | 3 | Access kind code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Right-justified scalar write payload |
| burst_wdata | input | 32*BURST_WORDS | Burst payload, word 0 in the low bits |
| test_mode | input | 1 | Reads return packed hidden pairs |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Read result |

## Verification
The bench builds the block with MEM_BYTES of 128, BURST_WORDS of 8 and ADDR_W of 12. This small memory lets addresses wrap on scalar accesses, and burst bases from 128 to 4095 reach the out-of-range rule. The test-mode read of the last halfword wraps its second pair back to index zero. With four lines of 32 bytes, a random stream mixing all eight kind codes revisits the same bytes often, so ordering effects between hidden-bit writes, data-only writes and reads appear many times.

// File: rtl/msb_pkg.sv
package msb_pkg;

   typedef enum logic [2:0] {
      K_BYTE   = 3'd0,
      K_HALF   = 3'd1,
      K_WORD   = 3'd2,
      K_DWORD  = 3'd3,
      K_BURST4 = 3'd4,
      K_BURST8 = 3'd5
   } acc_kind_e;

   localparam int SCALAR_BYTES = 8;

   // byte count of a scalar access kind
   function automatic int unsigned acc_bytes(logic [2:0] kind);
      case (kind)
         K_BYTE:  return 1;
         K_HALF:  return 2;
         K_WORD:  return 4;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/msb_decode.sv
module msb_decode
   import msb_pkg::*;
#(
   parameter  int MEM_BYTES   = 256,
   parameter  int ADDR_W      = 32,
   parameter  int BURST_WORDS = 8,
   localparam int LINE_BYTES  = BURST_WORDS * 4,
   localparam int LOFF_W      = $clog2(LINE_BYTES),
   localparam int MEM_AW      = $clog2(MEM_BYTES),
   localparam int LINE_W      = MEM_AW - LOFF_W,
   localparam int LEN_W       = LOFF_W + 1
) (
   input  logic                        run,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [2:0]                  req_kind,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [63:0]                 req_wdata,
   input  logic [BURST_WORDS*32-1:0]   burst_wdata,
   output logic [LINE_W-1:0]           line_idx,
   output logic [LINE_BYTES-1:0]       byte_we,
   output logic [LINE_BYTES*8-1:0]     byte_wd,
   output logic [LINE_BYTES-1:0]       hid_we,
   output logic [LINE_BYTES-1:0]       hid_wd,
   output logic                        rd_req,
   output logic [LOFF_W-1:0]           rd_off,
   output logic [3:0]                  rd_len
);

   localparam int B4_BYTES = 16;

   logic              live;
   logic              in_range;
   logic              b8_ok;
   logic              is_scalar;
   logic              is_wr;
   int unsigned       n_bytes;
   logic [LOFF_W-1:0] off_raw;
   logic [LOFF_W-1:0] win_off;
   logic [LEN_W-1:0]  win_len;

   // the long-burst kind exists only when a line holds eight words
   if (BURST_WORDS == 8) begin : g_b8
      assign b8_ok = (req_kind == K_BURST8);
   end else begin : g_nob8
      assign b8_ok = 1'b0;
   end

   assign live      = run & req_valid;
   assign off_raw   = req_addr[LOFF_W-1:0];
   assign line_idx  = req_addr[MEM_AW-1:LOFF_W];
   assign in_range  = (req_addr < ADDR_W'(MEM_BYTES));
   assign is_scalar = (req_kind <= K_DWORD);

   always_comb begin
      n_bytes = acc_bytes(req_kind);
      win_off = '0;
      win_len = '0;
      is_wr   = 1'b0;
      if (is_scalar) begin
         win_off = off_raw & ~LOFF_W'(n_bytes - 1);
         win_len = LEN_W'(n_bytes);
         is_wr   = live & req_write;
      end else if (req_kind == K_BURST4) begin
         win_off = off_raw & ~LOFF_W'(B4_BYTES - 1);
         win_len = LEN_W'(B4_BYTES);
         is_wr   = live & req_write & in_range;
      end else if (b8_ok) begin
         win_off = '0;
         win_len = LEN_W'(LINE_BYTES);
         is_wr   = live & req_write & in_range;
      end
   end

   assign rd_req = live & ~req_write & is_scalar;
   assign rd_off = win_off;
   assign rd_len = 4'(n_bytes);

   for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
      int         rel;
      logic       inwin;
      logic [7:0] lane_wd;

      always_comb begin
         rel     = k - int'(win_off);
         inwin   = (k >= int'(win_off)) && (k < int'(win_off) + int'(win_len));
         lane_wd = '0;
         if (inwin) begin
            if (is_scalar)
               lane_wd = 8'(req_wdata >> (8 * (int'(n_bytes) - 1 - rel)));
            else
               lane_wd = 8'(burst_wdata >> (32 * (rel / 4) + 8 * (3 - rel % 4)));
         end
      end

      assign byte_we[k]        = is_wr & inwin;
      assign byte_wd[8*k +: 8] = lane_wd;
      assign hid_we[k]         = is_wr & inwin &
                                 ((req_kind == K_BYTE) || (req_kind == K_HALF));
      assign hid_wd[k]         = ((req_kind == K_HALF) || ((k % 2) == 1)) ?
                                 req_wdata[0] : 1'b0;
   end

endmodule

// File: rtl/msb_data_store.sv
module msb_data_store #(
   parameter  int LINES      = 8,
   parameter  int LINE_BYTES = 32,
   localparam int LINE_W     = $clog2(LINES)
) (
   input  logic                    clk,
   input  logic                    clr_n,
   input  logic [LINE_W-1:0]       line_idx,
   input  logic [LINE_BYTES-1:0]   byte_we,
   input  logic [LINE_BYTES*8-1:0] byte_wd,
   output logic [LINE_BYTES*8-1:0] line_rd
);

   logic [7:0] mem [LINES][LINE_BYTES];

   always_ff @(posedge clk) begin
      if (!clr_n) begin
         for (int l = 0; l < LINES; l++)
            for (int b = 0; b < LINE_BYTES; b++)
               mem[l][b] <= '0;
      end else begin
         for (int b = 0; b < LINE_BYTES; b++)
            if (byte_we[b])
               mem[line_idx][b] <= byte_wd[8*b +: 8];
      end
   end

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_rd
      assign line_rd[8*b +: 8] = mem[line_idx][b];
   end

endmodule

// File: rtl/msb_hidden_store.sv
module msb_hidden_store #(
   parameter  int LINES      = 8,
   parameter  int LINE_BYTES = 32,
   localparam int LINE_W     = $clog2(LINES),
   localparam int PAIRS      = LINES * LINE_BYTES / 2,
   localparam int PAIR_W     = $clog2(PAIRS)
) (
   input  logic                  clk,
   input  logic                  clr_n,
   input  logic [LINE_W-1:0]     line_idx,
   input  logic [LINE_BYTES-1:0] hid_we,
   input  logic [LINE_BYTES-1:0] hid_wd,
   input  logic [PAIR_W-1:0]     rd_pair,
   output logic [1:0]            pair_a,
   output logic [1:0]            pair_b
);

   logic [1:0]        pairs [PAIRS];
   logic [PAIR_W-1:0] rd_next;

   always_ff @(posedge clk) begin
      if (!clr_n) begin
         for (int p = 0; p < PAIRS; p++)
            pairs[p] <= '0;
      end else begin
         for (int k = 0; k < LINE_BYTES; k++)
            if (hid_we[k])
               pairs[(int'(line_idx) * LINE_BYTES + k) / 2][1 - (k % 2)] <= hid_wd[k];
      end
   end

   // pair count is a power of two, so the increment wraps on its own
   assign rd_next = rd_pair + PAIR_W'(1);
   assign pair_a  = pairs[rd_pair];
   assign pair_b  = pairs[rd_next];

endmodule

// File: rtl/mem_sideband.sv
module mem_sideband
   import msb_pkg::*;
#(
   parameter int MEM_BYTES   = 256,
   parameter int ADDR_W      = 32,
   parameter int BURST_WORDS = 8
) (
   input  logic                      clk,
   input  logic                      por_n,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [2:0]                req_kind,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [63:0]               req_wdata,
   input  logic [BURST_WORDS*32-1:0] burst_wdata,
   input  logic                      test_mode,
   output logic                      rd_valid,
   output logic [63:0]               rd_data
);

   localparam int LINE_BYTES = BURST_WORDS * 4;
   localparam int LOFF_W     = $clog2(LINE_BYTES);
   localparam int MEM_AW     = $clog2(MEM_BYTES);
   localparam int LINES      = MEM_BYTES / LINE_BYTES;
   localparam int LINE_W     = MEM_AW - LOFF_W;
   localparam int PAIR_W     = MEM_AW - 1;

   if ((1 << MEM_AW) != MEM_BYTES) begin : g_bad_pow2
      $error("MEM_BYTES must be a power of two");
   end
   if (BURST_WORDS != 4 && BURST_WORDS != 8) begin : g_bad_burst
      $error("BURST_WORDS must be 4 or 8");
   end
   if (LINES < 2) begin : g_bad_lines
      $error("MEM_BYTES must hold at least two burst lines");
   end
   if (ADDR_W < MEM_AW) begin : g_bad_addr
      $error("ADDR_W too narrow for MEM_BYTES");
   end

   logic                    run;
   logic [LINE_W-1:0]       line_idx;
   logic [LINE_BYTES-1:0]   byte_we;
   logic [LINE_BYTES*8-1:0] byte_wd;
   logic [LINE_BYTES-1:0]   hid_we;
   logic [LINE_BYTES-1:0]   hid_wd;
   logic                    rd_req;
   logic [LOFF_W-1:0]       rd_off;
   logic [3:0]              rd_len;
   logic [LINE_BYTES*8-1:0] line_rd;
   logic [PAIR_W-1:0]       rd_pair;
   logic [1:0]              pair_a;
   logic [1:0]              pair_b;
   logic [63:0]             rd_word;

   assign run = por_n & rst_n;

   msb_decode #(
      .MEM_BYTES   (MEM_BYTES),
      .ADDR_W      (ADDR_W),
      .BURST_WORDS (BURST_WORDS)
   ) u_dec (
      .run         (run),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_kind    (req_kind),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .burst_wdata (burst_wdata),
      .line_idx    (line_idx),
      .byte_we     (byte_we),
      .byte_wd     (byte_wd),
      .hid_we      (hid_we),
      .hid_wd      (hid_wd),
      .rd_req      (rd_req),
      .rd_off      (rd_off),
      .rd_len      (rd_len)
   );

   msb_data_store #(
      .LINES      (LINES),
      .LINE_BYTES (LINE_BYTES)
   ) u_data (
      .clk      (clk),
      .clr_n    (por_n),
      .line_idx (line_idx),
      .byte_we  (byte_we),
      .byte_wd  (byte_wd),
      .line_rd  (line_rd)
   );

   assign rd_pair = PAIR_W'({line_idx, rd_off} >> 1);

   msb_hidden_store #(
      .LINES      (LINES),
      .LINE_BYTES (LINE_BYTES)
   ) u_hid (
      .clk      (clk),
      .clr_n    (por_n),
      .line_idx (line_idx),
      .hid_we   (hid_we),
      .hid_wd   (hid_wd),
      .rd_pair  (rd_pair),
      .pair_a   (pair_a),
      .pair_b   (pair_b)
   );

   // big-endian gather of the addressed bytes, right-justified
   always_comb begin
      rd_word = '0;
      for (int i = 0; i < SCALAR_BYTES; i++)
         if (i < int'(rd_len))
            rd_word = {rd_word[55:0],
                       line_rd[8 * ((int'(rd_off) + i) % LINE_BYTES) +: 8]};
   end

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (!rd_req)
            rd_data <= '0;
         else if (test_mode)
            rd_data <= {60'd0, pair_a, pair_b};
         else
            rd_data <= rd_word;
      end
   end

endmodule

// File: rtl/msb_chk.sv
module msb_chk #(
   parameter int LINE_BYTES = 32
) (
   input logic                  clk,
   input logic                  por_n,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_write,
   input logic [2:0]            req_kind,
   input logic                  test_mode,
   input logic                  rd_valid,
   input logic [63:0]           rd_data,
   input logic [LINE_BYTES-1:0] hid_we
);

   // R11
   write_no_rdvalid_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (req_valid && req_write) |=> !rd_valid);

   // R1
   rdvalid_after_read_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      rd_valid |-> $past(req_valid && !req_write && (req_kind <= 3'd3)));

   // R7
   test_read_narrow_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (rd_valid && $past(test_mode)) |-> (rd_data[63:4] == 60'd0));

   // R4
   wide_write_keeps_hidden_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (req_valid && req_write && (req_kind >= 3'd2)) |-> (hid_we == '0));

   // R9
   por_quiets_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !por_n |=> !rd_valid);

   // R10
   soft_reset_quiets_out_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> !rd_valid);

endmodule

bind mem_sideband msb_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_kind  (req_kind),
   .test_mode (test_mode),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .hid_we    (hid_we)
);

// File: tb/sim_mem_sideband.sv
`timescale 1ns/1ps
module sim_mem_sideband;

   localparam int MEMB = 128;
   localparam int AW   = 12;
   localparam int BW   = 8;

   logic            clk = 1'b0;
   logic            por_n = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [2:0]      req_kind = '0;
   logic [AW-1:0]   req_addr = '0;
   logic [63:0]     req_wdata = '0;
   logic [BW*32-1:0] burst_wdata = '0;
   logic            test_mode = 1'b0;
   logic            rd_valid;
   logic [63:0]     rd_data;

   int checks = 0;
   int errors = 0;

   // behavioural model: one data byte and one hidden bit per address
   logic [7:0] m_data [MEMB];
   logic       m_hid  [MEMB];
   logic       e_valid;
   logic [63:0] e_data;

   always #5 clk = ~clk;

   mem_sideband #(.MEM_BYTES(MEMB), .ADDR_W(AW), .BURST_WORDS(BW)) u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
      .req_write(req_write), .req_kind(req_kind), .req_addr(req_addr),
      .req_wdata(req_wdata), .burst_wdata(burst_wdata), .test_mode(test_mode),
      .rd_valid(rd_valid), .rd_data(rd_data));

   function automatic int kbytes(int k);
      return (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 4 : 8;
   endfunction

   task automatic model_step();
      int n, a, h, h2, len, b;
      logic [31:0] w;
      e_valid = 1'b0;
      e_data  = '0;
      if (!por_n) begin
         for (int i = 0; i < MEMB; i++) begin m_data[i] = '0; m_hid[i] = 1'b0; end
      end else if (rst_n && req_valid) begin
         if (req_kind <= 3) begin
            n = kbytes(int'(req_kind));
            a = int'(req_addr) % MEMB;
            a = a - (a % n);
            if (!req_write) begin
               e_valid = 1'b1;
               if (test_mode) begin
                  h  = a / 2;
                  h2 = (h + 1) % (MEMB / 2);
                  e_data = {60'd0, m_hid[2*h], m_hid[2*h+1], m_hid[2*h2], m_hid[2*h2+1]};
               end else begin
                  for (int i = 0; i < n; i++) e_data = {e_data[55:0], m_data[a+i]};
               end
            end else begin
               for (int i = 0; i < n; i++) m_data[a+i] = 8'(req_wdata >> (8*(n-1-i)));
               if (req_kind == 0) m_hid[a] = (a % 2 == 1) ? req_wdata[0] : 1'b0;
               if (req_kind == 1) begin m_hid[a] = req_wdata[0]; m_hid[a+1] = req_wdata[0]; end
            end
         end else if (req_write && (req_kind == 4 || req_kind == 5) && int'(req_addr) < MEMB) begin
            len = (req_kind == 4) ? 16 : 32;
            b = int'(req_addr);
            b = b - (b % len);
            for (int i = 0; i < len / 4; i++) begin
               w = burst_wdata[32*i +: 32];
               for (int j = 0; j < 4; j++) m_data[b+4*i+j] = 8'(w >> (8*(3-j)));
            end
         end
      end
   endtask

   // one clock: drive at the falling edge, compare after the rising edge
   task automatic cyc(input logic v, input logic wr, input int kind, input int addr,
                      input logic [63:0] wd, input logic tm, input string tag);
      @(negedge clk);
      req_valid = v; req_write = wr; req_kind = 3'(kind); req_addr = AW'(addr);
      req_wdata = wd; test_mode = tm;
      model_step();
      @(posedge clk);
      #1;
      checks++;
      if (rd_valid !== e_valid || rd_data !== e_data) begin
         errors++;
         $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                  tag, rd_valid, rd_data, e_valid, e_data);
      end
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 1'b0, 0, 0, 64'd0, 1'b0, tag);
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R9 cold power-up
      idle("R9");
      idle("R9");
      por_n = 1'b1;
      idle("R10");
      rst_n = 1'b1;
      cyc(1, 0, 3, 'h00, 0, 0, "R9");
      cyc(1, 0, 2, 'h00, 0, 1, "R9");
      // R2 byte writes, odd sets from data bit 0, even clears
      cyc(1, 1, 0, 'h01, 64'h01, 0, "R2");
      cyc(1, 1, 0, 'h00, 64'hFF, 0, "R2");
      cyc(1, 1, 0, 'h03, 64'hFE, 0, "R2");
      cyc(1, 1, 0, 'h02, 64'h03, 0, "R2");
      cyc(1, 0, 2, 'h00, 0, 1, "R7");
      cyc(1, 0, 0, 'h01, 0, 0, "R2");
      // R3 halfword writes
      cyc(1, 1, 1, 'h04, 64'h1235, 0, "R3");
      cyc(1, 1, 1, 'h07, 64'h0002, 0, "R3");
      cyc(1, 0, 2, 'h04, 0, 1, "R3");
      cyc(1, 0, 1, 'h06, 0, 0, "R3");
      // R4 word and doubleword keep hidden bits
      cyc(1, 1, 2, 'h04, 64'hAABBCCDD, 0, "R4");
      cyc(1, 0, 2, 'h04, 0, 1, "R4");
      cyc(1, 0, 2, 'h06, 0, 0, "R4");
      cyc(1, 1, 3, 'h0B, 64'h0123456789ABCDEF, 0, "R4");
      cyc(1, 0, 3, 'h08, 0, 0, "R4");
      // R8 reads leave state alone
      cyc(1, 0, 2, 'h04, 0, 1, "R8");
      cyc(1, 0, 2, 'h00, 0, 0, "R8");
      // R5 bursts
      for (int i = 0; i < BW; i++) burst_wdata[32*i +: 32] = 32'hC0DE0000 + 32'(i);
      cyc(1, 1, 1, 'h22, 64'h0001, 0, "R5");
      cyc(1, 1, 4, 'h23, 0, 0, "R5");
      cyc(1, 0, 2, 'h2C, 0, 0, "R5");
      cyc(1, 0, 2, 'h22, 0, 1, "R5");
      cyc(1, 1, 5, 'h5F, 0, 0, "R5");
      cyc(1, 0, 3, 'h58, 0, 0, "R5");
      // R6 out-of-range bursts ignored
      for (int i = 0; i < BW; i++) burst_wdata[32*i +: 32] = 32'hDEAD0000 + 32'(i);
      cyc(1, 1, 5, 'h80, 0, 0, "R6");
      cyc(1, 1, 4, 'h95, 0, 0, "R6");
      cyc(1, 0, 3, 'h00, 0, 0, "R6");
      cyc(1, 0, 3, 'h10, 0, 0, "R6");
      // R7 last halfword wraps to pair zero
      cyc(1, 1, 0, 'h7F, 64'h01, 0, "R7");
      cyc(1, 0, 1, 'h7E, 0, 1, "R7");
      // R1 address wrap on scalar access
      cyc(1, 1, 0, 'h85, 64'h5A, 0, "R1");
      cyc(1, 0, 0, 'h05, 0, 0, "R1");
      cyc(1, 0, 3, 'h83, 0, 0, "R1");
      // R11 odd kinds and burst reads
      cyc(1, 1, 6, 'h00, 64'hFFFF, 0, "R11");
      cyc(1, 1, 7, 'h08, 64'hFFFF, 0, "R11");
      cyc(1, 0, 5, 'h00, 0, 0, "R11");
      cyc(1, 0, 7, 'h00, 0, 0, "R11");
      cyc(1, 0, 3, 'h00, 0, 0, "R11");
      // R10 soft reset keeps contents and ignores requests
      rst_n = 1'b0;
      cyc(1, 1, 3, 'h00, 64'h1111, 0, "R10");
      cyc(1, 0, 3, 'h00, 0, 0, "R10");
      rst_n = 1'b1;
      cyc(1, 0, 3, 'h00, 0, 0, "R10");
      cyc(1, 0, 2, 'h00, 0, 1, "R10");
      // mixed stream against the model
      for (int r = 0; r < 600; r++) begin
         burst_wdata = {8{$urandom}};
         cyc($urandom % 5 != 0, 1'($urandom % 2), int'($urandom % 8), int'($urandom % 'h200),
             {$urandom, $urandom}, ($urandom % 3) == 0, "R1");
      end
      // R9 power-up clears everything
      por_n = 1'b0;
      cyc(1, 1, 3, 'h00, 64'h77, 0, "R9");
      por_n = 1'b1;
      for (int a = 0; a < MEMB; a += 8) cyc(1, 0, 3, a, 0, 0, "R9");
      for (int a = 0; a < MEMB; a += 4) cyc(1, 0, 2, a, 0, 1, "R9");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule